// File: doc/BRIEF.md
# Eight-Pin General-Purpose Port with Peripheral Pin Override

This block is one 8-pin bidirectional I/O port of a microcontroller-class chip. Software reaches it through a small register interface: a direction register (a 1 makes the pin an input), an output latch, a pin-state view of the synchronised pad levels and a control register that holds the global pull-up enable. Every pad gets an output value, an output enable and a pull-up enable from the block.

On-chip peripherals can take pins away from software control. Each claim has a fixed priority. The external memory bus wins over everything and uses the whole port as the upper address/data byte. Below it are the parallel-port strobes on pins 1 and 0, then the reference clock on pin 3, then the PWM outputs. Plain latch and direction control comes last. A remap strap moves two of the PWM units off this port. A second strap lets pin 7 carry a PWM unit's primary output. Weak pull-ups follow a single global bit and switch off on any pin that is being driven.

Top module: `gpio_override_port`

## Requirements
- R1: While reset is asserted, and right after it, the direction register reads 8'hFF, the latch reads 8'h00 and the pull-up control reads 0. pad_oe and pad_pu are all zero.
- R2: When no override is active on a pin, pad_out[i] equals latch bit i and pad_oe[i] equals the inverse of direction bit i.
- R3: A write to address 0 (pin view) or address 1 (latch) loads wr_data into the latch at the next clock edge. Reading address 1 returns the latch.
- R4: Reading address 0 returns pad_in after a two-flop synchroniser. A pad level present before clock edge k appears on rd_data after edge k+1.
- R5: Address 2 reads and writes the direction register. Address 3 holds the pull-up enable in bit 0, and its bits 7:1 read as 0.
- R6: pad_pu[i] is 1 only when the pull-up enable is 1 and pad_oe[i] is 0.
- R7: While xbus_en is 1, pad_out equals xbus_dout and every pad_oe bit equals xbus_oe, whatever the other controls are.
- R8: With xbus_en at 0, pmp_en at 1 and pmp_sel at 0, pin 1 drives pmp_wr and pin 0 drives pmp_rd, both enabled. This takes priority over the reference clock, PWM and latch.
- R9: With refo_en at 1 and no higher claim active, pin 3 drives refo_clk with its output enabled.
- R10: pwm_en[i] for pins 6:0 drives pwm_val[i] with the output enabled. When pwm_local is 0, pins 6, 5, 1 and 0 ignore pwm_en. pwm_en[7] is never used.
- R11: When alt_sel_n is 0 and pri_en is 1, pin 7 drives pri_val with its output enabled, at the same priority as the PWM outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 pin view, 1 latch, 2 direction, 3 control) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad weak pull-up enables |
| xbus_en | input | 1 | External memory bus owns the port |
| xbus_oe | input | 1 | Memory bus drives the pads |
| xbus_dout | input | 8 | Memory bus upper address/data byte out |
| xbus_din | output | 8 | Raw pad levels returned to the memory bus |
| pmp_en | input | 1 | Parallel port active |
| pmp_sel | input | 1 | Parallel-port strobe placement (0 puts the strobes on this port) |
| pmp_wr | input | 1 | Parallel-port write strobe |
| pmp_rd | input | 1 | Parallel-port read strobe |
| refo_en | input | 1 | Reference clock output enable |
| refo_clk | input | 1 | Reference clock |
| pwm_local | input | 1 | Remap strap (0 moves two PWM units off the port) |
| pwm_en | input | 8 | Per-pin PWM output active |
| pwm_val | input | 8 | Per-pin PWM output level |
| alt_sel_n | input | 1 | Pin-7 alternate strap (0 selects the primary PWM output) |
| pri_en | input | 1 | Primary PWM output active |
| pri_val | input | 1 | Primary PWM output level |

## Verification
The assertions assume that every override control and strap is a known value in each sampled cycle. They also assume that at most one register write arrives per clock, so the latch and the direction register each have exactly one source per edge. The bench changes all inputs only on the falling edge and draws addresses, strap values and enables from $urandom with a fixed seed. The external bus is enabled only about one cycle in eight, so the lower-priority paths are still exercised.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        ADDR_PIN = 2'd0,
        ADDR_LAT = 2'd1,
        ADDR_DIR = 2'd2,
        ADDR_CTL = 2'd3
    } reg_addr_e;

    localparam int unsigned PORT_W = 8;
endpackage

// File: rtl/port_sync.sv
module port_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign synced = st_q.s2;

    // R4
    sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s2 == $past(st_q.s1));
endmodule

// File: rtl/port_regs.sv
module port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] lat,
    output logic [W-1:0] dir,
    output logic         pu_ctl
);
    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] dir;
        logic         pu;
    } regs_t;

    regs_t r_d, r_q;
    reg_addr_e a;

    assign a = reg_addr_e'(addr);

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (a)
                ADDR_PIN, ADDR_LAT: r_d.lat = wr_data;
                ADDR_DIR:           r_d.dir = wr_data;
                ADDR_CTL:           r_d.pu  = wr_data[0];
                default:            r_d     = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.lat <= '0;
            r_q.dir <= '1;
            r_q.pu  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (a)
            ADDR_PIN: rd_data = pin_sync;
            ADDR_LAT: rd_data = r_q.lat;
            ADDR_DIR: rd_data = r_q.dir;
            ADDR_CTL: rd_data = {{(W-1){1'b0}}, r_q.pu};
            default:  rd_data = '0;
        endcase
    end

    assign lat    = r_q.lat;
    assign dir    = r_q.dir;
    assign pu_ctl = r_q.pu;

    // R3
    lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 2'd0 || addr == 2'd1)) |=> (lat == $past(wr_data)));
    // R5
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd2) |=> $stable(dir));
endmodule

// File: rtl/port_mux.sv
module port_mux #(
    parameter int unsigned W         = 8,
    parameter logic [W-1:0] PWM_PINS = 8'h7F,
    parameter logic [W-1:0] REMAP    = 8'h63,
    parameter int unsigned PIN_WR    = 1,
    parameter int unsigned PIN_RD    = 0,
    parameter int unsigned PIN_REFO  = 3,
    parameter int unsigned PIN_ALT   = 7
) (
    input  logic [W-1:0] lat,
    input  logic [W-1:0] dir,
    input  logic         pu_ctl,
    input  logic         xbus_en,
    input  logic         xbus_oe,
    input  logic [W-1:0] xbus_dout,
    input  logic         pmp_en,
    input  logic         pmp_sel,
    input  logic         pmp_wr,
    input  logic         pmp_rd,
    input  logic         refo_en,
    input  logic         refo_clk,
    input  logic         pwm_local,
    input  logic [W-1:0] pwm_en,
    input  logic [W-1:0] pwm_val,
    input  logic         alt_sel_n,
    input  logic         pri_en,
    input  logic         pri_val,
    output logic [W-1:0] out,
    output logic [W-1:0] oe,
    output logic [W-1:0] pu
);
    logic pmp_on;
    assign pmp_on = pmp_en && !pmp_sel;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            out[i] = lat[i];
            oe[i]  = ~dir[i];
            if (PWM_PINS[i] && pwm_en[i] && (pwm_local || !REMAP[i])) begin
                out[i] = pwm_val[i];
                oe[i]  = 1'b1;
            end
            if (i == PIN_ALT && !alt_sel_n && pri_en) begin
                out[i] = pri_val;
                oe[i]  = 1'b1;
            end
            if (i == PIN_REFO && refo_en) begin
                out[i] = refo_clk;
                oe[i]  = 1'b1;
            end
            if (pmp_on && i == PIN_WR) begin
                out[i] = pmp_wr;
                oe[i]  = 1'b1;
            end
            if (pmp_on && i == PIN_RD) begin
                out[i] = pmp_rd;
                oe[i]  = 1'b1;
            end
            if (xbus_en) begin
                out[i] = xbus_dout[i];
                oe[i]  = xbus_oe;
            end
        end
        pu = {W{pu_ctl}} & ~oe;
    end
endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu,
    input  logic              xbus_en,
    input  logic              xbus_oe,
    input  logic [PORT_W-1:0] xbus_dout,
    output logic [PORT_W-1:0] xbus_din,
    input  logic              pmp_en,
    input  logic              pmp_sel,
    input  logic              pmp_wr,
    input  logic              pmp_rd,
    input  logic              refo_en,
    input  logic              refo_clk,
    input  logic              pwm_local,
    input  logic [PORT_W-1:0] pwm_en,
    input  logic [PORT_W-1:0] pwm_val,
    input  logic              alt_sel_n,
    input  logic              pri_en,
    input  logic              pri_val
);
    logic [PORT_W-1:0] pin_sync, lat, dir;
    logic              pu_ctl;

    port_sync #(.W(PORT_W)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw(pad_in), .synced(pin_sync)
    );

    port_regs #(.W(PORT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .pin_sync(pin_sync), .rd_data(rd_data),
        .lat(lat), .dir(dir), .pu_ctl(pu_ctl)
    );

    port_mux #(.W(PORT_W)) mux_i (
        .lat(lat), .dir(dir), .pu_ctl(pu_ctl),
        .xbus_en(xbus_en), .xbus_oe(xbus_oe), .xbus_dout(xbus_dout),
        .pmp_en(pmp_en), .pmp_sel(pmp_sel), .pmp_wr(pmp_wr), .pmp_rd(pmp_rd),
        .refo_en(refo_en), .refo_clk(refo_clk), .pwm_local(pwm_local),
        .pwm_en(pwm_en), .pwm_val(pwm_val), .alt_sel_n(alt_sel_n),
        .pri_en(pri_en), .pri_val(pri_val),
        .out(pad_out), .oe(pad_oe), .pu(pad_pu)
    );

    assign xbus_din = pad_in;

    // R6
    pu_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);
    // R7
    xbus_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_en |-> (pad_out == xbus_dout && pad_oe == {PORT_W{xbus_oe}}));
    // R8
    pmp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xbus_en && pmp_en && !pmp_sel) |-> (pad_out[1:0] == {pmp_wr, pmp_rd} && pad_oe[1:0] == 2'b11));
    // R2
    plain_pin7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xbus_en && !(!alt_sel_n && pri_en)) |-> (pad_out[7] == lat[7] && pad_oe[7] == !dir[7]));
endmodule

// File: tb/gpio_override_port_tb.sv
module gpio_override_port_tb_top;
    logic clk = 0, rst_n = 0;
    logic wr_en = 0; logic [1:0] addr = 0; logic [7:0] wr_data = 0;
    logic [7:0] rd_data, pad_in = 0, pad_out, pad_oe, pad_pu, xbus_din;
    logic xbus_en = 0, xbus_oe = 0; logic [7:0] xbus_dout = 0;
    logic pmp_en = 0, pmp_sel = 0, pmp_wr = 0, pmp_rd = 0, refo_en = 0, refo_clk = 0;
    logic pwm_local = 0; logic [7:0] pwm_en = 0, pwm_val = 0;
    logic alt_sel_n = 1, pri_en = 0, pri_val = 0;

    int tests = 0, fails = 0;
    logic [7:0] m_lat = 0, m_dir = 8'hFF, s1 = 0, s2 = 0; logic m_pu = 0;

    always #5 clk = ~clk;

    gpio_override_port dut_i (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic void model(output logic [7:0] o, output logic [7:0] e, output logic [7:0] p);
        for (int i = 0; i < 8; i++) begin
            o[i] = m_lat[i]; e[i] = ~m_dir[i];
            if (i < 7 && pwm_en[i] && (pwm_local || !(i == 6 || i == 5 || i == 1 || i == 0))) begin
                o[i] = pwm_val[i]; e[i] = 1;
            end
            if (i == 7 && !alt_sel_n && pri_en) begin o[i] = pri_val; e[i] = 1; end
            if (i == 3 && refo_en) begin o[i] = refo_clk; e[i] = 1; end
            if (pmp_en && !pmp_sel && i == 1) begin o[i] = pmp_wr; e[i] = 1; end
            if (pmp_en && !pmp_sel && i == 0) begin o[i] = pmp_rd; e[i] = 1; end
            if (xbus_en) begin o[i] = xbus_dout[i]; e[i] = xbus_oe; end
        end
        p = {8{m_pu}} & ~e;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return s2;
            2'd1: return m_lat;
            2'd2: return m_dir;
            default: return {7'b0, m_pu};
        endcase
    endfunction

    task automatic check_all(input string tag);
        logic [7:0] o, e, p;
        model(o, e, p);
        chk({tag, " R2/R7-R11 pad_out"}, pad_out, o);
        chk({tag, " R2 pad_oe"}, pad_oe, e);
        chk({tag, " R6 pad_pu"}, pad_pu, p);
        chk({tag, " R3/R4/R5 rd_data"}, rd_data, exp_rd(addr));
    endtask

    task automatic tick();
        @(posedge clk);
        if (wr_en) case (addr)
            2'd0, 2'd1: m_lat = wr_data;
            2'd2: m_dir = wr_data;
            default: m_pu = wr_data[0];
        endcase
        s2 = s1; s1 = pad_in;
        @(negedge clk);
    endtask

    initial begin
        #200000; fails++; tests++;
        $display("FAIL watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            addr = a[1:0]; #1;
            chk("R1 reset rd_data", rd_data, a == 2 ? 8'hFF : 8'h00);
        end
        chk("R1 reset pad_oe", pad_oe, 8'h00);
        chk("R1 reset pad_pu", pad_pu, 8'h00);
        rst_n = 1;
        // R5 directed: pull-up on, all inputs; then bits 7:1 of control read 0
        wr_en = 1; addr = 3; wr_data = 8'hFF; tick(); wr_en = 0; #1;
        chk("R5 ctl upper bits", rd_data, 8'h01);
        chk("R6 all pulled", pad_pu, 8'hFF);
        // R3 write via pin address
        wr_en = 1; addr = 0; wr_data = 8'hA5; tick(); addr = 1; wr_en = 0; #1;
        chk("R3 latch via addr0", rd_data, 8'hA5);
        // R4 sync latency
        pad_in = 8'h3C; addr = 0; tick(); #1;
        chk("R4 after one edge", rd_data, 8'h00);
        tick(); #1;
        chk("R4 after two edges", rd_data, 8'h3C);
        // R10 remap: local off ignores pins 6,5,1,0
        wr_en = 1; addr = 2; wr_data = 8'hFF; tick(); wr_en = 0;
        pwm_en = 8'hFF; pwm_val = 8'hFF; pwm_local = 0; #1;
        chk("R10 remap off oe", pad_oe, 8'h1C);
        pwm_local = 1; #1;
        chk("R10 remap on oe", pad_oe, 8'h7F);
        // R8 pmp over refclk/pwm, R9 refclk over pwm
        pmp_en = 1; refo_en = 1; refo_clk = 0; pmp_wr = 0; pmp_rd = 1; #1;
        chk("R8 pmp strobes", pad_out[1:0], 2'b01);
        chk("R9 refclk over pwm", {7'b0, pad_out[3]}, 8'h00);
        pmp_en = 0; refo_en = 0; pwm_en = 0;
        for (int n = 0; n < 3000; n++) begin
            wr_en = ($urandom % 3) == 0; addr = $urandom; wr_data = $urandom;
            pad_in = $urandom; xbus_en = ($urandom % 8) == 0; xbus_oe = $urandom;
            xbus_dout = $urandom; pmp_en = $urandom; pmp_sel = $urandom;
            pmp_wr = $urandom; pmp_rd = $urandom; refo_en = $urandom; refo_clk = $urandom;
            pwm_local = $urandom; pwm_en = $urandom; pwm_val = $urandom;
            alt_sel_n = $urandom; pri_en = $urandom; pri_val = $urandom;
            #1; check_all("rand");
            tick();
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule